// File: doc/BRIEF.md
# Burst guard and tail bit prefixer

This block serializes one transmit burst. Software-side logic writes a 16-bit mode word that carries a guard-count field. When `start_i` is pulsed while idle, the block captures a parallel payload buffer and latches the guard count. It then emits a run of guard bits (all ones), three tail bits (all zeros) and the payload, most significant bit first. It emits one bit for each `bit_en_i` strobe.

The guard-count field sits at bits 10 down to 7 of the mode word. The field is stored offset by four, so a field value of 4 yields eight guard bits. A field value that would ask for more than eight guard bits is clamped to eight, and an error flag is raised while such a value is held. Bit 11 and every other bit outside the field are plain storage with no effect on the bit stream. Each emitted bit appears on a registered output with a valid flag. A one-cycle done pulse marks the last payload bit.

Top module: `burst_prefixer`

## Requirements
- R1: The mode word resets to 0x0000. A write with `cfg_we_i` high stores all 16 bits of `cfg_wdata_i`, and `cfg_o` shows the new value from the next cycle on.
- R2: For a guard field (mode bits 10:7) value F of 0 to 4, a burst starts with exactly F+4 guard bits. Field 0 gives 4 guard bits and field 4 gives 8.
- R3: Every guard bit is emitted as logic 1.
- R4: Exactly three tail bits of logic 0 follow the guard bits and precede the payload.
- R5: The payload is 142 bits, emitted as `payload_i[141]` first down to `payload_i[0]` last. It is captured on the accepted start, so later changes of `payload_i` do not alter the burst.
- R6: For a field value of 5 to 15, a burst carries exactly 8 guard bits, and `guard_err_o` is 1 while such a value is stored. For values 0 to 4, `guard_err_o` is 0.
- R7: Each `bit_en_i` strobe during a burst yields exactly one bit. `valid_o` and `bit_o` are registered and show that bit in the cycle after the strobe. Cycles without a strobe show `valid_o` low.
- R8: `done_o` is high for exactly one cycle, in the same cycle as the `valid_o` of the last payload bit.
- R9: A `start_i` during a burst is ignored, and the burst neither restarts nor lengthens. A `bit_en_i` strobe while idle produces no `valid_o`.
- R10: Mode bit 11 and all mode bits outside 10:7 have no effect on the emitted sequence.
- R11: A mode write during a burst does not change that burst's guard count. The count is latched at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Mode word write enable |
| cfg_wdata_i | input | 16 | Mode word write data |
| cfg_o | output | 16 | Stored mode word |
| guard_err_o | output | 1 | Stored guard field exceeds the ceiling |
| start_i | input | 1 | Begin a burst (accepted only when idle) |
| payload_i | input | 142 | Parallel payload, bit 141 sent first |
| bit_en_i | input | 1 | Bit strobe, one bit per strobe |
| bit_o | output | 1 | Serial bit |
| valid_o | output | 1 | `bit_o` carries a bit this cycle |
| done_o | output | 1 | Last payload bit is on `bit_o` |

## Verification
A mode write is visible on `cfg_o` and `guard_err_o` one cycle after the write edge. The bench therefore samples these at the following falling edge. Each bit appears on `bit_o`/`valid_o`/`done_o` one cycle after the strobe edge that consumes it. The bench raises a single strobe, waits one rising edge, and reads the result at the next falling edge, before it drives anything new. Gap cycles and one extra strobe after the burst are also sampled at falling edges, which confirms that nothing appears without a consumed strobe.

// File: rtl/burst_prefixer_pkg.sv
package burst_prefixer_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_GUARD = 2'd1,
    PH_TAIL  = 2'd2,
    PH_DATA  = 2'd3
  } phase_e;
endpackage

// File: rtl/bp_mode_reg.sv
module bp_mode_reg #(
  parameter int MODE_W    = 16,
  parameter int FIELD_LSB = 7,
  parameter int FIELD_W   = 4,
  parameter int GUARD_OFS = 4,
  parameter int GUARD_MAX = 8,
  parameter int CNT_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MODE_W-1:0] wdata_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [CNT_W-1:0]  guard_n_o,
  output logic              err_o
);
  logic [MODE_W-1:0]  mode_q;
  logic [FIELD_W-1:0] field;
  logic [CNT_W-1:0]   raw_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= '0;
    else if (we_i) mode_q <= wdata_i;
  end

  assign field = mode_q[FIELD_LSB +: FIELD_W];
  assign raw_n = {{(CNT_W-FIELD_W){1'b0}}, field} + CNT_W'(GUARD_OFS);

  always_comb begin
    err_o     = raw_n > CNT_W'(GUARD_MAX);
    guard_n_o = err_o ? CNT_W'(GUARD_MAX) : raw_n;
  end

  assign mode_o = mode_q;

  // R6: an out-of-range field always lands on the ceiling
  p_err_at_ceiling_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (guard_n_o == CNT_W'(GUARD_MAX)));
endmodule

// File: rtl/bp_phase_ctrl.sv
module bp_phase_ctrl
  import burst_prefixer_pkg::*;
#(
  parameter int PAY_LEN  = 142,
  parameter int TAIL_LEN = 3,
  parameter int CNT_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             bit_en_i,
  input  logic [CNT_W-1:0] guard_n_i,
  output phase_e           phase_o,
  output logic             load_o,
  output logic             shift_o,
  output logic             last_o
);
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: if (start_i) begin
        phase_d = PH_GUARD;
        cnt_d   = guard_n_i - 1'b1;
      end
      PH_GUARD: if (bit_en_i) begin
        if (cnt_q == '0) begin
          phase_d = PH_TAIL;
          cnt_d   = CNT_W'(TAIL_LEN - 1);
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_TAIL: if (bit_en_i) begin
        if (cnt_q == '0) begin
          phase_d = PH_DATA;
          cnt_d   = CNT_W'(PAY_LEN - 1);
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_DATA: if (bit_en_i) begin
        if (cnt_q == '0) phase_d = PH_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o = phase_q;
  assign load_o  = (phase_q == PH_IDLE) && start_i;
  assign shift_o = (phase_q == PH_DATA) && bit_en_i;
  assign last_o  = shift_o && (cnt_q == '0);

  // R9: a start during a burst without a strobe leaves the sequencer untouched
  p_start_busy_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE && start_i && !bit_en_i) |=> ($stable(cnt_q) && $stable(phase_q)));
  // R2: a burst always opens with at least four guard bits
  p_guard_floor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && start_i) |=> (phase_q == PH_GUARD && cnt_q >= CNT_W'(3)));
endmodule

// File: rtl/bp_payload_sr.sv
module bp_payload_sr #(
  parameter int PAY_LEN = 142
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [PAY_LEN-1:0] data_i,
  output logic               msb_o
);
  logic [PAY_LEN-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (load_i)   sr_q <= data_i;
    else if (shift_i)  sr_q <= {sr_q[PAY_LEN-2:0], 1'b0};
  end

  assign msb_o = sr_q[PAY_LEN-1];

  // R5: buffer holds between shifts
  p_hold_no_shift_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(sr_q));
endmodule

// File: rtl/burst_prefixer.sv
module burst_prefixer
  import burst_prefixer_pkg::*;
#(
  parameter int MODE_W    = 16,
  parameter int FIELD_LSB = 7,
  parameter int FIELD_W   = 4,
  parameter int GUARD_OFS = 4,
  parameter int GUARD_MAX = 8,
  parameter int TAIL_LEN  = 3,
  parameter int PAY_LEN   = 142
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [MODE_W-1:0]  cfg_wdata_i,
  output logic [MODE_W-1:0]  cfg_o,
  output logic               guard_err_o,
  input  logic               start_i,
  input  logic [PAY_LEN-1:0] payload_i,
  input  logic               bit_en_i,
  output logic               bit_o,
  output logic               valid_o,
  output logic               done_o
);
  localparam int CNT_W = $clog2(PAY_LEN + 1);

  logic [CNT_W-1:0] guard_n;
  phase_e           phase;
  logic             load, shift, last, pay_msb;
  logic             bit_q, valid_q, done_q;

  bp_mode_reg #(
    .MODE_W(MODE_W), .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W),
    .GUARD_OFS(GUARD_OFS), .GUARD_MAX(GUARD_MAX), .CNT_W(CNT_W)
  ) u_mode (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
    .mode_o(cfg_o), .guard_n_o(guard_n), .err_o(guard_err_o)
  );

  bp_phase_ctrl #(
    .PAY_LEN(PAY_LEN), .TAIL_LEN(TAIL_LEN), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .start_i, .bit_en_i, .guard_n_i(guard_n),
    .phase_o(phase), .load_o(load), .shift_o(shift), .last_o(last)
  );

  bp_payload_sr #(.PAY_LEN(PAY_LEN)) u_sr (
    .clk_i, .rst_ni,
    .load_i(load), .shift_i(shift), .data_i(payload_i), .msb_o(pay_msb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= bit_en_i && (phase != PH_IDLE);
      done_q  <= last;
      if (bit_en_i) begin
        unique case (phase)
          PH_GUARD: bit_q <= 1'b1;
          PH_TAIL:  bit_q <= 1'b0;
          PH_DATA:  bit_q <= pay_msb;
          default:  bit_q <= 1'b0;
        endcase
      end
    end
  end

  assign bit_o   = bit_q;
  assign valid_o = valid_q;
  assign done_o  = done_q;

  p_guard_ones_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_GUARD && bit_en_i) |=> (valid_o && bit_o));
  p_tail_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_TAIL && bit_en_i) |=> (valid_o && !bit_o));
  p_valid_needs_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(bit_en_i));
  p_done_with_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> valid_o);
  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/burst_prefixer_bench.sv
`timescale 1ns/1ps
module burst_prefixer_bench;
  localparam int PL = 142;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [15:0]   cfg_wdata = '0;
  logic [15:0]   cfg_rd;
  logic          g_err;
  logic          start = 1'b0;
  logic [PL-1:0] payload = '0;
  logic          bit_en = 1'b0;
  logic          bit_s, valid_s, done_s;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  burst_prefixer u_burst_prefixer (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_o(cfg_rd), .guard_err_o(g_err),
    .start_i(start), .payload_i(payload), .bit_en_i(bit_en),
    .bit_o(bit_s), .valid_o(valid_s), .done_o(done_s)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [PL-1:0] make_payload(input int seed);
    logic [PL-1:0] p;
    for (int i = 0; i < PL; i++) p[i] = ((i * 7 + seed * 13 + (i >> 3)) % 5) < 2;
    return p;
  endfunction

  // runs a full burst; optional start and mode write at strobe index 5
  task automatic burst(input logic [PL-1:0] pay, input int gap, input int exp_guard,
                       input bit mid, input logic [15:0] mid_mode, input string tag);
    int total, seq_err, first_bad, act_b, exp_b, done_n, done_at, gap_err;
    total = exp_guard + 3 + PL;
    seq_err = 0; first_bad = -1; act_b = 0; exp_b = 0;
    done_n = 0; done_at = -1; gap_err = 0;
    @(negedge clk);
    start = 1'b1; payload = pay;
    @(negedge clk);
    start = 1'b0; payload = ~pay;  // R5: capture happened on start
    for (int k = 0; k < total; k++) begin
      bit_en = 1'b1;
      if (mid && k == 5) begin
        start = 1'b1; cfg_we = 1'b1; cfg_wdata = mid_mode;
      end
      @(negedge clk);
      bit_en = 1'b0; start = 1'b0; cfg_we = 1'b0;
      if (k < exp_guard) exp_b = 1;
      else if (k < exp_guard + 3) exp_b = 0;
      else exp_b = int'(pay[PL-1-(k-exp_guard-3)]);
      if (!valid_s || int'(bit_s) != exp_b) begin
        if (first_bad < 0) begin
          first_bad = k; act_b = valid_s ? int'(bit_s) : -1;
        end
        seq_err++;
      end
      if (done_s) begin done_n++; done_at = k; end
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        if (valid_s) gap_err++;
      end
    end
    if (first_bad >= 0)
      check(1'b0, {tag, " R2 R3 R4 R5 sequence"}, act_b,
            first_bad < exp_guard ? 1 : (first_bad < exp_guard + 3 ? 0 : -2));
    else
      check(1'b1, {tag, " R2 R3 R4 R5 sequence"}, 0, 0);
    check(done_n == 1 && done_at == total - 1, {tag, " R8 done position"}, done_at, total - 1);
    check(gap_err == 0, {tag, " R7 no valid in gaps"}, gap_err, 0);
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    check(!valid_s, {tag, " R9 idle strobe ignored"}, int'(valid_s), 0);
  endtask

  task automatic t_reset;
    check(cfg_rd == 16'h0000, "R1 reset mode", int'(cfg_rd), 0);
    check(!valid_s && !done_s, "R7 reset outputs idle", int'({valid_s, done_s}), 0);
    check(!g_err, "R6 reset no error", int'(g_err), 0);
  endtask

  task automatic t_field4;
    write_mode(16'h0200);
    check(cfg_rd == 16'h0200, "R1 readback", int'(cfg_rd), 16'h0200);
    check(!g_err, "R6 field 4 no error", int'(g_err), 0);
    burst(make_payload(1), 0, 8, 1'b0, '0, "field4");
  endtask

  task automatic t_field0_gapped;
    write_mode(16'h0000);
    burst(make_payload(2), 2, 4, 1'b0, '0, "field0 gap2");
    burst({PL{1'b1}}, 1, 4, 1'b0, '0, "field0 ones");
  endtask

  task automatic t_clamp;
    write_mode(16'h0380);
    check(g_err, "R6 field 7 error", int'(g_err), 1);
    burst(make_payload(3), 0, 8, 1'b0, '0, "field7 R6");
    write_mode(16'h0780);
    check(g_err, "R6 field 15 error", int'(g_err), 1);
    burst('0, 0, 8, 1'b0, '0, "field15 R6");
  endtask

  task automatic t_other_bits;
    write_mode(16'hFA7F);
    check(cfg_rd == 16'hFA7F, "R1 R10 readback with bit 11", int'(cfg_rd), 16'hFA7F);
    check(!g_err, "R10 other bits no error", int'(g_err), 0);
    burst(make_payload(4), 0, 8, 1'b0, '0, "bit11 R10");
  endtask

  task automatic t_mid_burst;
    write_mode(16'h0000);
    burst(make_payload(5), 1, 4, 1'b1, 16'h0200, "midstart R9 R11");
    check(cfg_rd == 16'h0200, "R11 mid write stored", int'(cfg_rd), 16'h0200);
    burst(make_payload(6), 0, 8, 1'b0, '0, "after mid R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_field4();
    t_field0_gapped();
    t_clamp();
    t_other_bits();
    t_mid_burst();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule